// File: doc/BRIEF.md
# Timer Compare Unit with Period Trigger

This block keeps a 16-bit up-counting timer and a 16-bit compare value and checks them for equality on every clock. When the timer arrives at the compare value, a 4-bit action code chooses the response. The response can drive a compare output latch high, drive it low, or raise only the compare interrupt flag. It can also fire a trigger that restarts the timer from zero and emits a one-cycle pulse to start an external converter. The trigger response turns the compare value into a programmable period: the timer counts 0..N and starts again.

Software programs the unit through a byte-wide write port. The port reaches the two timer bytes, the two compare bytes, the action code and an output-disable bit. The compare latch reaches a pad through a data/drive pair. Two sticky flags, one for compare and one for timer wrap, are cleared through a write-one-to-clear input.

Top module: `tcu_compare_unit`

## Requirements
- R1: With `timerEn` high and no timer write or trigger, `timerValue` rises by one per clock. It wraps from 0xFFFF to 0x0000, and on that wrap `ovfFlag` is set at the same edge.
- R2: A write with `wrEn` high stores `wrData` at the edge. Address 0 holds the timer low byte, 1 the timer high byte, 2 the compare low byte and 3 the compare high byte. Address 4 holds the action code in `wrData[3:0]`, and address 5 holds the output-disable bit in `wrData[0]`. A timer byte write takes priority over counting and over the trigger clear in that cycle.
- R3: A match is equality of all 16 timer and compare bits. It causes one action when the timer arrives at the compare value. A match held over many cycles causes no further action until the timer leaves the value and comes back.
- R4: Action code 4'b1000 sets the compare latch on a match and 4'b1001 clears it. The new latch value is visible at the edge that ends the first matching cycle.
- R5: Any action code from 4'b1000 to 4'b1011 sets `cmpFlag` at the same edge as the match action.
- R6: Action code 4'b1010 sets `cmpFlag` on a match and leaves the compare latch unchanged.
- R7: Action code 4'b1011 clears the timer to zero on a match. It does not set `ovfFlag`, even when the compare value is 0xFFFF. When `convEnable` is high it also drives `convStart` high for exactly one cycle.
- R8: Action codes outside 4'b1000..4'b1011 cause no latch change, no flag and no trigger on a match.
- R9: A write of 8'h00 to address 4 forces the compare latch low. A nonzero write to that address does not touch the latch, even when the stored action code becomes zero.
- R10: `pinDrive` is the inverse of the output-disable bit. `pinData` shows the compare latch while `pinDrive` is high and is 0 otherwise.
- R11: `cmpFlag` and `ovfFlag` stay set until `flagClr[0]` or `flagClr[1]` is high at an edge. A set in the same cycle as a clear wins.
- R12: After reset, every register is zero: the timer, the compare value, the action code, the output-disable bit, the latch, both flags and `convStart`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| timerEn | input | 1 | Count enable for the timer |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 8 | Register write data |
| flagClr | input | 2 | Write-one-to-clear: bit 0 compare flag, bit 1 wrap flag |
| convEnable | input | 1 | Allows the trigger action to pulse `convStart` |
| timerValue | output | 16 | Current timer count |
| pinData | output | 1 | Compare latch value toward the pad |
| pinDrive | output | 1 | High while the pad is driven; low leaves it released |
| cmpFlag | output | 1 | Sticky compare interrupt flag |
| ovfFlag | output | 1 | Sticky timer wrap flag |
| convStart | output | 1 | One-cycle converter start pulse |

## Verification
The bench targets a compare value of 0xFFFF under the trigger action, where the wrap and the clear collide. A design that let the increment win would set the wrap flag, and one that cleared late would show 0x0000 one cycle too late. It holds the timer still on the compare value and clears the flag. A design that acted on the level rather than the arrival would set the flag again at once. It writes 8'hF0 to the action code, which leaves a zero code but must keep the latch. It runs the trigger with the converter enabled and disabled to catch a missing gate or a stretched pulse. Each of these is checked against a behavioural model on every clock.

// File: rtl/tcu_pkg.sv
package tcu_pkg;

  localparam int MODE_W = 4;

  localparam logic [MODE_W-1:0] MODE_SET  = 4'b1000;
  localparam logic [MODE_W-1:0] MODE_CLR  = 4'b1001;
  localparam logic [MODE_W-1:0] MODE_FLAG = 4'b1010;
  localparam logic [MODE_W-1:0] MODE_TRIG = 4'b1011;

  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic latchSet;
    logic latchClr;
    logic flagSet;
    logic timerClr;
    logic convPulse;
  } tcuStrobe_t;

endpackage

// File: rtl/tcu_datapath.sv
module tcu_datapath
  import tcu_pkg::*;
#(
  parameter int TIMER_W = 16,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 timerEn,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [1:0]           flagClr,
  input  tcuStrobe_t           strobe,
  output logic [TIMER_W-1:0]   timerValue,
  output logic                 matchNow,
  output logic [MODE_W-1:0]    modeValue,
  output logic                 latchQ,
  output logic                 outDisable,
  output logic                 cmpFlag,
  output logic                 ovfFlag,
  output logic                 convStart
);

  localparam int NBYTES    = TIMER_W / DATA_W;
  localparam int ADDR_CMP0 = NBYTES;
  localparam int ADDR_MODE = 2 * NBYTES;
  localparam int ADDR_DIS  = 2 * NBYTES + 1;

  logic [TIMER_W-1:0] timer, cmpReg, timerLoad, cmpLoad;
  logic [NBYTES-1:0]  timerWr, cmpWr;
  logic               timerAnyWr, cmpAnyWr, modeWr, disWr, modeZeroWrite, wrapTick;
  logic [MODE_W-1:0]  modeReg;

  for (genvar k = 0; k < NBYTES; k++) begin : g_byteSel
    assign timerWr[k] = wrEn && (wrAddr == ADDR_W'(k));
    assign cmpWr[k]   = wrEn && (wrAddr == ADDR_W'(ADDR_CMP0 + k));
  end

  always_comb begin
    timerLoad = timer;
    cmpLoad   = cmpReg;
    for (int k = 0; k < NBYTES; k++) begin
      if (timerWr[k]) timerLoad[k*DATA_W +: DATA_W] = wrData;
      if (cmpWr[k])   cmpLoad[k*DATA_W +: DATA_W]   = wrData;
    end
  end

  assign timerAnyWr    = |timerWr;
  assign cmpAnyWr      = |cmpWr;
  assign modeWr        = wrEn && (wrAddr == ADDR_W'(ADDR_MODE));
  assign disWr         = wrEn && (wrAddr == ADDR_W'(ADDR_DIS));
  assign modeZeroWrite = modeWr && (wrData == '0);
  assign wrapTick      = timerEn && !timerAnyWr && !strobe.timerClr && (timer == '1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timer      <= '0;
      cmpReg     <= '0;
      modeReg    <= '0;
      outDisable <= 1'b0;
    end else begin
      if (timerAnyWr)           timer <= timerLoad;
      else if (strobe.timerClr) timer <= '0;
      else if (timerEn)         timer <= timer + TIMER_W'(1);
      if (cmpAnyWr) cmpReg     <= cmpLoad;
      if (modeWr)   modeReg    <= wrData[MODE_W-1:0];
      if (disWr)    outDisable <= wrData[0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchQ    <= 1'b0;
      cmpFlag   <= 1'b0;
      ovfFlag   <= 1'b0;
      convStart <= 1'b0;
    end else begin
      if (modeZeroWrite)        latchQ <= 1'b0;
      else if (strobe.latchSet) latchQ <= 1'b1;
      else if (strobe.latchClr) latchQ <= 1'b0;
      if (strobe.flagSet)       cmpFlag <= 1'b1;
      else if (flagClr[0])      cmpFlag <= 1'b0;
      if (wrapTick)             ovfFlag <= 1'b1;
      else if (flagClr[1])      ovfFlag <= 1'b0;
      convStart <= strobe.convPulse;
    end
  end

  assign timerValue = timer;
  assign matchNow   = (timer == cmpReg);
  assign modeValue  = modeReg;

  // R1
  timer_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (timerEn && !timerAnyWr && !strobe.timerClr) |=> (timer == $past(timer) + TIMER_W'(1)));

  // R7
  timer_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.timerClr && !timerAnyWr && !ovfFlag) |=> (timer == '0) && !ovfFlag);

  // R7
  conv_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);

  // R6
  flag_mode_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeReg == MODE_FLAG && !modeZeroWrite) |=> (latchQ == $past(latchQ)));

  // R9
  zero_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeZeroWrite |=> !latchQ);

  // R11
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmpFlag && !flagClr[0]) |=> cmpFlag);

endmodule

// File: rtl/tcu_control.sv
module tcu_control
  import tcu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              matchNow,
  input  logic [MODE_W-1:0] modeValue,
  input  logic              convEnable,
  output tcuStrobe_t        strobe
);

  logic matchPrev, arrive, active;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) matchPrev <= 1'b0;
    else       matchPrev <= matchNow;
  end

  // act only when the timer arrives at the compare value
  assign arrive = matchNow && !matchPrev;
  assign active = arrive && (modeValue[MODE_W-1:MODE_W-2] == 2'b10);

  always_comb begin
    strobe           = '0;
    strobe.flagSet   = active;
    strobe.latchSet  = active && (modeValue == MODE_SET);
    strobe.latchClr  = active && (modeValue == MODE_CLR);
    strobe.timerClr  = active && (modeValue == MODE_TRIG);
    strobe.convPulse = strobe.timerClr && convEnable;
  end

  // R3
  no_retrig_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flagSet |=> !strobe.flagSet);

endmodule

// File: rtl/tcu_compare_unit.sv
module tcu_compare_unit
  import tcu_pkg::*;
#(
  parameter int TIMER_W = 16,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               timerEn,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [1:0]         flagClr,
  input  logic               convEnable,
  output logic [TIMER_W-1:0] timerValue,
  output logic               pinData,
  output logic               pinDrive,
  output logic               cmpFlag,
  output logic               ovfFlag,
  output logic               convStart
);

  tcuStrobe_t        strobe;
  logic              matchNow, latchQ, outDisable;
  logic [MODE_W-1:0] modeValue;

  tcu_control i_control (
    .clk        (clk),
    .rstN       (rstN),
    .matchNow   (matchNow),
    .modeValue  (modeValue),
    .convEnable (convEnable),
    .strobe     (strobe)
  );

  tcu_datapath #(
    .TIMER_W (TIMER_W),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .timerEn    (timerEn),
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .flagClr    (flagClr),
    .strobe     (strobe),
    .timerValue (timerValue),
    .matchNow   (matchNow),
    .modeValue  (modeValue),
    .latchQ     (latchQ),
    .outDisable (outDisable),
    .cmpFlag    (cmpFlag),
    .ovfFlag    (ovfFlag),
    .convStart  (convStart)
  );

  assign pinDrive = !outDisable;
  assign pinData  = latchQ && !outDisable;

endmodule

// File: tb/test_tcu_compare_unit.sv
module test_tcu_compare_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        timerEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic [1:0]  flagClr = '0;
  logic        convEnable = 1'b0;
  logic [15:0] timerValue;
  logic        pinData, pinDrive, cmpFlag, ovfFlag, convStart;

  int checks = 0;
  int failures = 0;
  bit running = 1'b0;
  bit finished = 1'b0;

  // behavioural reference state
  int mTimer, mCmp, mMode, mDis, mLatch, mCf, mOf, mConv, mPrev;

  always #2 clk = ~clk;

  tcu_compare_unit i_tcu_compare_unit (
    .clk(clk), .rstN(rstN), .timerEn(timerEn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .flagClr(flagClr), .convEnable(convEnable),
    .timerValue(timerValue), .pinData(pinData), .pinDrive(pinDrive),
    .cmpFlag(cmpFlag), .ovfFlag(ovfFlag), .convStart(convStart)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mTimer = 0; mCmp = 0; mMode = 0; mDis = 0; mLatch = 0;
      mCf = 0; mOf = 0; mConv = 0; mPrev = 0;
    end else begin
      bit hit, act, wrap;
      int nT;
      hit  = (mTimer == mCmp);
      act  = hit && !mPrev && (mMode >= 8) && (mMode <= 11);
      wrap = 1'b0;
      nT   = mTimer;
      if (wrEn && wrAddr == 0)      nT = (mTimer & 'hFF00) | wrData;
      else if (wrEn && wrAddr == 1) nT = (mTimer & 'h00FF) | (int'(wrData) << 8);
      else if (act && mMode == 11)  nT = 0;
      else if (timerEn) begin
        wrap = (mTimer == 'hFFFF);
        nT = (mTimer + 1) & 'hFFFF;
      end
      if (wrEn && wrAddr == 4 && wrData == 0) mLatch = 0;
      else if (act && mMode == 8)             mLatch = 1;
      else if (act && mMode == 9)             mLatch = 0;
      if (act) mCf = 1; else if (flagClr[0]) mCf = 0;
      if (wrap) mOf = 1; else if (flagClr[1]) mOf = 0;
      mConv = (act && mMode == 11 && convEnable) ? 1 : 0;
      mPrev = hit;
      if (wrEn && wrAddr == 2) mCmp = (mCmp & 'hFF00) | wrData;
      if (wrEn && wrAddr == 3) mCmp = (mCmp & 'h00FF) | (int'(wrData) << 8);
      if (wrEn && wrAddr == 4) mMode = wrData & 'hF;
      if (wrEn && wrAddr == 5) mDis = wrData & 1;
      mTimer = nT;
    end
  end

  always @(negedge clk) begin
    if (running) begin
      chk("R1 timerValue", timerValue, mTimer);
      chk("R1 ovfFlag", ovfFlag, mOf);
      chk("R4 pinData", pinData, mDis ? 0 : mLatch);
      chk("R10 pinDrive", pinDrive, mDis ? 0 : 1);
      chk("R5 cmpFlag", cmpFlag, mCf);
      chk("R7 convStart", convStart, mConv);
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk); #1;
    wrEn = 1'b1; wrAddr = a[2:0]; wrData = d[7:0];
    @(negedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic pulseClr(int b);
    @(negedge clk); #1;
    flagClr = b[1:0];
    @(negedge clk); #1;
    flagClr = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setTimer(int v);
    wr(0, v & 'hFF);
    wr(1, (v >> 8) & 'hFF);
  endtask

  task automatic setCmp(int v);
    wr(2, v & 'hFF);
    wr(3, (v >> 8) & 'hFF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int pulses, maxT;
    repeat (3) @(negedge clk);
    #1 rstN = 1'b1;
    running = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 timer", timerValue, 0);
    chk("R12 pinData", pinData, 0);
    chk("R12 pinDrive", pinDrive, 1);
    chk("R12 flags", {cmpFlag, ovfFlag, convStart}, 0);

    // R2 byte writes into timer
    setTimer('h1234);
    chk("R2 timer bytes", timerValue, 'h1234);

    // R4 set on match, R5 flag
    setCmp('h1240);
    wr(4, 'h08);
    timerEn = 1'b1;
    idle(20);
    chk("R4 latch set", pinData, 1);
    chk("R5 flag set", cmpFlag, 1);
    pulseClr(1);
    chk("R11 cmp flag clear", cmpFlag, 0);

    // R3 held match does not repeat
    timerEn = 1'b0;
    setTimer('h1240);
    idle(3);
    pulseClr(1);
    idle(6);
    chk("R3 held match", cmpFlag, 0);
    chk("R3 timer held", timerValue, 'h1240);

    // R4 clear on match
    setTimer('h1230);
    wr(4, 'h09);
    timerEn = 1'b1;
    idle(20);
    chk("R4 latch clear", pinData, 0);

    // R6 flag-only code keeps latch
    timerEn = 1'b0;
    wr(4, 'h08);
    setTimer('h1230);
    timerEn = 1'b1;
    idle(20);
    timerEn = 1'b0;
    wr(4, 'h0A);
    setTimer('h1230);
    pulseClr(1);
    timerEn = 1'b1;
    idle(20);
    chk("R6 latch kept", pinData, 1);
    chk("R6 flag set", cmpFlag, 1);

    // R8 inactive code
    timerEn = 1'b0;
    wr(4, 'h05);
    setTimer('h1230);
    pulseClr(1);
    timerEn = 1'b1;
    idle(20);
    chk("R8 no flag", cmpFlag, 0);
    chk("R8 latch kept", pinData, 1);

    // R9 only an all-zero write clears the latch
    wr(4, 'hF0);
    chk("R9 nonzero write", pinData, 1);
    wr(4, 'h00);
    chk("R9 zero write", pinData, 0);

    // R10 output disable
    wr(4, 'h08);
    timerEn = 1'b0;
    setTimer('h1230);
    timerEn = 1'b1;
    idle(20);
    wr(5, 'h01);
    chk("R10 released drive", pinDrive, 0);
    chk("R10 released data", pinData, 0);
    wr(5, 'h00);
    chk("R10 driven data", pinData, 1);

    // R7 period trigger with converter pulse
    timerEn = 1'b0;
    wr(4, 'h00);
    setCmp('h0005);
    setTimer(0);
    convEnable = 1'b1;
    wr(4, 'h0B);
    timerEn = 1'b1;
    pulses = 0; maxT = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (convStart) pulses++;
      if (timerValue > maxT) maxT = timerValue;
    end
    chk("R7 period bound", maxT, 5);
    chk("R7 pulse seen", (pulses >= 5) ? 1 : 0, 1);
    convEnable = 1'b0;
    pulses = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (convStart) pulses++;
    end
    chk("R7 pulse gated", pulses, 0);

    // R7 trigger at 0xFFFF must not raise the wrap flag
    timerEn = 1'b0;
    setCmp('hFFFF);
    setTimer('hFFF0);
    pulseClr(3);
    timerEn = 1'b1;
    idle(30);
    chk("R7 no wrap flag", ovfFlag, 0);
    chk("R7 restarted", (timerValue < 'h20) ? 1 : 0, 1);

    // R1 wrap with inactive code
    timerEn = 1'b0;
    wr(4, 'h00);
    setTimer('hFFF8);
    timerEn = 1'b1;
    idle(16);
    timerEn = 1'b0;
    chk("R1 wrap flag", ovfFlag, 1);
    chk("R1 wrapped count", timerValue, 'h0008);
    pulseClr(2);
    chk("R11 wrap flag clear", ovfFlag, 0);

    idle(2);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule